// File: doc/BRIEF.md
# Rail Enable Delay and Routing

This block sits between the raw enable requests of three supply rails (two switching rails and one linear rail) and the controllers that act on them. First, two routing controls can re-map the requests. One lets the first switching rail's request also drive the second switching rail. The other exchanges the request paths of the second switching rail and the linear rail. After routing, the linear rail's enable passes through an edge-delay stage. That stage can hold back an asserting edge and a deasserting edge by separately chosen times.

Delays are counted in whole ticks of a 1 ms strobe input. Each 3-bit delay code selects a tick count from a fixed table that is not geometric. The switching rails pass through the same stage with a code of zero, so all three outputs are registered one clock after their routed request. A single configuration byte holds both delay codes and both routing controls. Its cleared value gives zero delay and no routing.

Top module: `rail_en_delay_route`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every enable output goes low and any pending delay is discarded. A delay that starts after reset is counted in full.
- R2: When the routed linear-rail request rises while its output is low, the output rises at the clock edge that samples the N-th tick after the edge was detected. N is the tick count selected by `cfg_i[2:0]`.
- R3: When that request falls while its output is high, the output falls at the edge that samples the N-th tick. Here N is selected by `cfg_i[5:3]`, and the rising code plays no part.
- R4: Code to tick count: 0→0, 1→2, 2→4, 3→8, 4→16, 5→24, 6→32, 7→64.
- R5: A code of 0 moves the output to the new level at the first clock edge that sees the changed request, whether or not a tick is present.
- R6: While a delay is pending, the output changes only at an edge where `tick_i` is high.
- R7: If the request returns to the output's level before the count expires, the pending change is cancelled and the output keeps its level. This includes the case where the return falls in the same cycle as the final tick.
- R8: With `cfg_i[7]`=1 and `cfg_i[6]`=0, `en_sw2_o` follows `req_sw1_i` one cycle later, and `req_sw2_i` is ignored.
- R9: With `cfg_i[6]`=1 and `cfg_i[7]`=0, the linear rail is driven by `req_sw2_i` and `en_sw2_o` is driven by `req_ldo_i`.
- R10: The merge control acts before the exchange. With both bits set, the linear rail follows `req_sw1_i` and `en_sw2_o` follows `req_ldo_i`.
- R11: A delay code is captured when an edge is detected. Changes to `cfg_i` while the delay is pending do not alter that delay.
- R12: `en_sw1_o` equals `req_sw1_i` delayed by exactly one clock, with no tick dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe every millisecond |
| cfg_i | input | 8 | [7] merge, [6] exchange, [5:3] fall code, [2:0] rise code |
| req_sw1_i | input | 1 | Raw enable request, first switching rail |
| req_sw2_i | input | 1 | Raw enable request, second switching rail |
| req_ldo_i | input | 1 | Raw enable request, linear rail |
| en_sw1_o | output | 1 | Enable to first switching rail controller |
| en_sw2_o | output | 1 | Enable to second switching rail controller |
| en_ldo_o | output | 1 | Delayed enable to linear rail controller |

## Verification
The expiry of a pending delay and its cancellation can fall in the same cycle. This happens when the request drops back on the very cycle that carries the final tick. The bench provokes this by driving the request back low and pulsing the tick together. It expects the output to stay low, and to stay low through further ticks, because cancellation takes precedence. A configuration change in the same stretch as a pending count is also provoked. It is judged by the output switching after the tick count captured at detection.

// File: rtl/rail_en_pkg.sv
// Shared definitions for the rail enable delay/routing block.
// Assumes the configuration byte layout below is fixed by its decoder.
package rail_en_pkg;

    localparam int CODE_W = 3;
    localparam int TICK_W = 7;   // wide enough for the largest table entry (64)

    typedef struct packed {
        logic              merge;   // [7]
        logic              xchg;    // [6]
        logic [CODE_W-1:0] fall;    // [5:3]
        logic [CODE_W-1:0] rise;    // [2:0]
    } rail_cfg_t;

    // Map a delay code onto a tick count.
    function automatic logic [TICK_W-1:0] code_ticks(input logic [CODE_W-1:0] code);
        logic [TICK_W-1:0] t;
        case (code)
            3'd0:    t = TICK_W'(0);
            3'd1:    t = TICK_W'(2);
            3'd2:    t = TICK_W'(4);
            3'd3:    t = TICK_W'(8);
            3'd4:    t = TICK_W'(16);
            3'd5:    t = TICK_W'(24);
            3'd6:    t = TICK_W'(32);
            default: t = TICK_W'(64);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rail_en_route.sv
// Request routing: applies merge first, then the exchange.
// Assumes request inputs are already synchronous to clk. Purely combinational.
module rail_en_route #(
    parameter int NRAIL = 3
) (
    input  logic             merge_i,
    input  logic             xchg_i,
    input  logic [NRAIL-1:0] req_i,    // [0] sw1, [1] sw2, [2] ldo
    output logic [NRAIL-1:0] path_o
);

    logic sw2_merged;

    // Merge stage then exchange stage.
    always_comb begin
        sw2_merged = merge_i ? req_i[0] : req_i[1];
        path_o     = req_i;
        path_o[1]  = xchg_i ? req_i[2]   : sw2_merged;
        path_o[2]  = xchg_i ? sw2_merged : req_i[2];
    end

endmodule

// File: rtl/rail_en_edge_delay.sv
// Edge delay for one enable: holds the output for a tick count chosen by the
// rise or fall code, captured when the edge is detected. Assumes tick_i is a
// single-cycle strobe. A request that returns to the output level cancels.
module rail_en_edge_delay #(
    parameter int CNT_W = rail_en_pkg::TICK_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          req_i,
    input  logic [rail_en_pkg::CODE_W-1:0] rise_code_i,
    input  logic [rail_en_pkg::CODE_W-1:0] fall_code_i,
    output logic                          en_o
);

    logic             q;
    logic             pend;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;

    // Select the tick count for the direction of the pending edge.
    always_comb begin
        load = CNT_W'(rail_en_pkg::code_ticks(req_i ? rise_code_i : fall_code_i));
    end

    // Detect edges, count ticks, cancel on return, update the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= 1'b0;
            pend <= 1'b0;
            cnt  <= '0;
        end else if (req_i == q) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (!pend) begin
            if (load == '0) begin
                q <= req_i;
            end else begin
                pend <= 1'b1;
                cnt  <= load;
            end
        end else if (tick_i) begin
            if (cnt == CNT_W'(1)) begin
                q    <= req_i;
                pend <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign en_o = q;

    // R5: zero code passes the edge at the next clock.
    a_r5_zero_code_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && (req_i != q) && (load == '0)) |=> (en_o == $past(req_i)));

    // R6: no output change without a tick while pending.
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tick_i) |=> $stable(en_o));

    // R7: a returning request clears the pending state and keeps the level.
    a_r7_cancel_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (req_i == q)) |=> (!pend && $stable(en_o)));

    // R2: a pending count is never empty.
    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (cnt != '0));

endmodule

// File: rtl/rail_en_delay_route.sv
// Top: routes three rail enable requests and delays the linear-rail enable
// per the configuration byte. Switching rails use the delay stage with a zero
// code, so all outputs register one clock after their routed request.
module rail_en_delay_route #(
    parameter int NRAIL   = 3,
    parameter int LDO_IDX = 2,
    parameter int CNT_W   = rail_en_pkg::TICK_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [7:0] cfg_i,
    input  logic       req_sw1_i,
    input  logic       req_sw2_i,
    input  logic       req_ldo_i,
    output logic       en_sw1_o,
    output logic       en_sw2_o,
    output logic       en_ldo_o
);

    import rail_en_pkg::*;

    rail_cfg_t        cfg;
    logic [NRAIL-1:0] req;
    logic [NRAIL-1:0] path;
    logic [NRAIL-1:0] en;

    // Unpack configuration and gather requests.
    always_comb begin
        cfg = rail_cfg_t'(cfg_i);
        req = {req_ldo_i, req_sw2_i, req_sw1_i};
    end

    rail_en_route #(.NRAIL(NRAIL)) u_route (
        .merge_i (cfg.merge),
        .xchg_i  (cfg.xchg),
        .req_i   (req),
        .path_o  (path)
    );

    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        logic [CODE_W-1:0] rc;
        logic [CODE_W-1:0] fc;
        if (g == LDO_IDX) begin : g_dly
            assign rc = cfg.rise;
            assign fc = cfg.fall;
        end else begin : g_pass
            assign rc = '0;
            assign fc = '0;
        end
        rail_en_edge_delay #(.CNT_W(CNT_W)) u_dly (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .req_i       (path[g]),
            .rise_code_i (rc),
            .fall_code_i (fc),
            .en_o        (en[g])
        );
    end

    assign en_sw1_o = en[0];
    assign en_sw2_o = en[1];
    assign en_ldo_o = en[LDO_IDX];

    // R1: reset drives all enables low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!en_sw1_o && !en_sw2_o && !en_ldo_o));

    // R12: first switching rail is a one-clock copy of its request.
    a_r12_sw1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_sw1_o == $past(req_sw1_i)));

    // R8: merge only, second switching rail follows the first request.
    a_r8_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[7] && !cfg_i[6]) |=> (en_sw2_o == $past(req_sw1_i)));

    // R9/R10: with the exchange set, second switching rail takes the linear request.
    a_r9_xchg_sw2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[6] |=> (en_sw2_o == $past(req_ldo_i)));

endmodule

// File: tb/tb_rail_en_delay_route.sv
module tb_rail_en_delay_route;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [7:0] cfg_i = 8'h00;
    logic       req_sw1_i = 1'b0;
    logic       req_sw2_i = 1'b0;
    logic       req_ldo_i = 1'b0;
    logic       en_sw1_o, en_sw2_o, en_ldo_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_en_delay_route dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_i(cfg_i),
        .req_sw1_i(req_sw1_i), .req_sw2_i(req_sw2_i), .req_ldo_i(req_ldo_i),
        .en_sw1_o(en_sw1_o), .en_sw2_o(en_sw2_o), .en_ldo_o(en_ldo_o)
    );

    function automatic int exp_ticks(input int code);
        int t[8] = '{0, 2, 4, 8, 16, 24, 32, 64};
        return t[code];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            step();
            tick_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 reset sw1", en_sw1_o, 1'b0);
        chk("R1 reset sw2", en_sw2_o, 1'b0);
        chk("R1 reset ldo", en_ldo_o, 1'b0);
    endtask

    task automatic t_sw_pass();
        req_sw1_i = 1'b1; req_sw2_i = 1'b1;
        step();
        chk("R12 sw1 rise", en_sw1_o, 1'b1);
        chk("R12 sw2 own", en_sw2_o, 1'b1);
        req_sw1_i = 1'b0; req_sw2_i = 1'b0;
        step();
        chk("R12 sw1 fall", en_sw1_o, 1'b0);
    endtask

    task automatic t_zero_code();
        cfg_i = 8'h00;
        req_ldo_i = 1'b1;
        step();
        chk("R5 zero rise no tick", en_ldo_o, 1'b1);
        req_ldo_i = 1'b0;
        step();
        chk("R5 zero fall no tick", en_ldo_o, 1'b0);
    endtask

    task automatic t_rise_table();
        for (int c = 1; c < 8; c++) begin
            cfg_i = 8'(c);
            req_ldo_i = 1'b1;
            step();
            ticks(exp_ticks(c) - 1);
            chk($sformatf("R4 code %0d before last tick", c), en_ldo_o, 1'b0);
            ticks(1);
            chk($sformatf("R2 code %0d at last tick", c), en_ldo_o, 1'b1);
            cfg_i = 8'h00;
            req_ldo_i = 1'b0;
            step();
        end
    endtask

    task automatic t_fall();
        cfg_i = {2'b00, 3'd1, 3'd7};    // fall 2 ticks, rise 64 ticks
        req_ldo_i = 1'b1;
        step();
        ticks(64);
        chk("R2 rise 64", en_ldo_o, 1'b1);
        req_ldo_i = 1'b0;
        step();
        ticks(1);
        chk("R3 fall held", en_ldo_o, 1'b1);
        ticks(1);
        chk("R3 fall after 2", en_ldo_o, 1'b0);
    endtask

    task automatic t_hold();
        cfg_i = {5'b00000, 3'd1};
        req_ldo_i = 1'b1;
        step();
        ticks(1);
        repeat (20) step();
        chk("R6 no change without tick", en_ldo_o, 1'b0);
        ticks(1);
        chk("R6 change on tick", en_ldo_o, 1'b1);
        cfg_i = 8'h00; req_ldo_i = 1'b0;
        step();
    endtask

    task automatic t_cancel();
        cfg_i = {5'b00000, 3'd2};       // 4 ticks
        req_ldo_i = 1'b1;
        step();
        ticks(2);
        req_ldo_i = 1'b0;
        step();
        ticks(5);
        chk("R7 early cancel", en_ldo_o, 1'b0);
        req_ldo_i = 1'b1;
        step();
        ticks(3);
        req_ldo_i = 1'b0;
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
        chk("R7 cancel on final tick", en_ldo_o, 1'b0);
        ticks(4);
        chk("R7 stays after cancel", en_ldo_o, 1'b0);
    endtask

    task automatic t_cfg_change();
        cfg_i = {5'b00000, 3'd1};       // 2 ticks captured
        req_ldo_i = 1'b1;
        step();
        cfg_i = {5'b00000, 3'd7};
        ticks(2);
        chk("R11 captured code used", en_ldo_o, 1'b1);
        cfg_i = 8'h00; req_ldo_i = 1'b0;
        step();
    endtask

    task automatic t_merge();
        cfg_i = 8'h80;
        req_sw1_i = 1'b1; req_sw2_i = 1'b0;
        step();
        chk("R8 sw2 follows sw1 high", en_sw2_o, 1'b1);
        req_sw1_i = 1'b0; req_sw2_i = 1'b1;
        step();
        chk("R8 own sw2 ignored", en_sw2_o, 1'b0);
        req_sw2_i = 1'b0;
    endtask

    task automatic t_xchg();
        cfg_i = 8'h40;
        req_sw2_i = 1'b1; req_ldo_i = 1'b0;
        step();
        chk("R9 ldo from sw2 request", en_ldo_o, 1'b1);
        chk("R9 sw2 from ldo request", en_sw2_o, 1'b0);
        req_sw2_i = 1'b0; req_ldo_i = 1'b1;
        step();
        chk("R9 sw2 from ldo high", en_sw2_o, 1'b1);
        chk("R9 ldo from sw2 low", en_ldo_o, 1'b0);
        req_ldo_i = 1'b0;
        step();
    endtask

    task automatic t_merge_xchg();
        cfg_i = 8'hC0;
        req_sw1_i = 1'b1; req_sw2_i = 1'b0; req_ldo_i = 1'b0;
        step();
        chk("R10 ldo follows sw1", en_ldo_o, 1'b1);
        chk("R10 sw2 follows ldo req", en_sw2_o, 1'b0);
        req_sw1_i = 1'b0; req_ldo_i = 1'b1;
        step();
        chk("R10 sw2 follows ldo high", en_sw2_o, 1'b1);
        chk("R10 ldo follows sw1 low", en_ldo_o, 1'b0);
        req_ldo_i = 1'b0; cfg_i = 8'h00;
        step();
    endtask

    task automatic t_reset_pending();
        cfg_i = {5'b00000, 3'd7};
        req_ldo_i = 1'b1; req_sw1_i = 1'b1;
        step();
        ticks(3);
        rst_n = 1'b0;
        step();
        chk("R1 reset clears sw1", en_sw1_o, 1'b0);
        chk("R1 reset clears ldo", en_ldo_o, 1'b0);
        rst_n = 1'b1;
        step();
        ticks(63);
        chk("R1 full count after reset", en_ldo_o, 1'b0);
        ticks(1);
        chk("R1 rise after full count", en_ldo_o, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_sw_pass();
        t_zero_code();
        t_rise_table();
        t_fall();
        t_hold();
        t_cancel();
        t_cfg_change();
        t_merge();
        t_xchg();
        t_merge_xchg();
        t_reset_pending();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule